// File: doc/BRIEF.md
# SPI Register Command Engine

This block is a mode-0 SPI slave. It turns a short byte-oriented protocol into single-cycle read and write strobes on an internal register bus. The SPI pins are oversampled by the system clock. Every byte the master sends is assembled, and the next byte for the master to read is loaded onto the output between bytes. The master must leave enough system clocks between bytes for that load to happen.

Each frame opens with a command byte and then a low address byte. The command byte gives the direction, the payload size and the upper address bits. On a write, the master then sends the data bytes. When checking is enabled, one CRC byte follows the master's bytes. The slave answers with a single status byte that accepts or rejects the command. On an accepted read, the data bytes follow that status byte. No frame delimiter exists beyond this byte count. An inactivity timer abandons a frame that stalls partway through. A busy signal from the register side makes the engine refuse commands and discard bytes until it is released.

Top module: `spi_cmd_engine`

## Requirements
- R1: After reset, and at the start of every frame, the slave shifts out 0xC1 while the command byte arrives and 0xC2 while the address byte arrives. Its data output is high (bit 7 of 0xC1) straight after reset.
- R2: In the command byte, bit 7 selects write (1) or read (0), and bits 5:4 select a payload of 1, 2, 4 or 8 bytes (codes 0 to 3). Bits 3:0 form address bits 11:8, and the second byte forms address bits 7:0. The full address appears on `reg_addr` when the strobe is issued.
- R3: After the last byte from the master (the address on a read, the last data byte on a write, or the CRC byte), the next byte the slave returns is 0x41 if it accepts the command or 0x4E if it rejects it. On a rejection, the frame ends after that status byte.
- R4: An accepted read issues one single-cycle `reg_rd` strobe. It captures `reg_rdata` in that cycle. After the 0x41 status byte, it returns the payload bytes lowest byte first. Bytes from the master during this time are ignored.
- R5: On a write, the slave outputs 0x00 while the data bytes arrive. The data arrives lowest byte first. An accepted write issues one single-cycle `reg_wr` strobe. `reg_wdata` holds the received bytes at their positions, and the bytes beyond the payload are zero.
- R6: When `cfg_crc_en` is high, the master sends one extra byte after its other bytes, and the slave outputs 0x00 during it. That byte must equal a CRC-8 (polynomial 0x07, initial value 0x00, most significant bit first) over the command, address and write-data bytes. A mismatch yields 0x4E and no strobe.
- R7: If `reg_busy` is high when the decision is made, the slave returns 0x4E and issues no strobe. While busy stays high after that status byte, every byte that arrives is discarded and answered with 0x4E. No strobe is ever issued while `reg_busy` is high.
- R8: If no byte completes for `cfg_timeout` system clocks while a frame is partly received, the frame is dropped without any strobe, and the next byte is taken as a command. A value of 0 disables the timer.
- R9: Once a frame ends and busy is low, the very next byte is decoded as a new command, with no gap or delimiter needed.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; also oversamples the SPI pins |
| rst_n | input | 1 | Active-low asynchronous reset |
| spi_sclk | input | 1 | SPI serial clock, idle low (mode 0) |
| spi_csn | input | 1 | SPI select, active low; deselect clears a partial byte |
| spi_mosi | input | 1 | Serial data from the master, sampled on rising sclk |
| spi_miso | output | 1 | Serial data to the master, updated after falling sclk |
| cfg_crc_en | input | 1 | Expect and check a trailing CRC byte |
| cfg_timeout | input | 16 | Inactivity limit in system clocks; 0 disables |
| reg_busy | input | 1 | Register side cannot take a command |
| reg_rd | output | 1 | Single-cycle read strobe |
| reg_wr | output | 1 | Single-cycle write strobe |
| reg_addr | output | 12 | Register address |
| reg_wdata | output | 64 | Write data, payload byte 0 in bits 7:0 |
| reg_rdata | input | 64 | Read data, sampled during `reg_rd` |

## Verification
The assertions check several properties on every cycle. A byte-complete event never lasts more than one cycle. Strobes are single pulses, and none follows a cycle in which busy was high. The hold state never issues a strobe. A CRC mismatch always leads to the rejecting status. A timer expiry always leaves the engine waiting for a command with no partial byte. The byte values on the serial output cannot be seen by a per-cycle property: the headers, the status codes, the lowest-byte-first data order and the CRC arithmetic. The bench scenarios alone show these. They also show that the timer really does let the next frame start cleanly, and that bytes arriving in the hold state are discarded.

// File: rtl/spi_cmd_pkg.sv
package spi_cmd_pkg;

  localparam int ADDR_W = 12;

  localparam logic [7:0] HDR_CMD  = 8'hC1;
  localparam logic [7:0] HDR_ADR  = 8'hC2;
  localparam logic [7:0] RSP_ACK  = 8'h41;
  localparam logic [7:0] RSP_NACK = 8'h4E;
  localparam logic [7:0] FILL     = 8'h00;
  localparam logic [7:0] CRC_POLY = 8'h07;

  typedef enum logic [2:0] {
    ST_CMD,   // waiting for a command byte
    ST_ADR,   // low address byte
    ST_WDAT,  // write payload bytes
    ST_CRC,   // check byte from the master
    ST_STAT,  // accepting status byte in flight
    ST_RDAT,  // read payload bytes in flight
    ST_NSTAT, // rejecting status byte in flight
    ST_HOLD   // busy: discard bytes
  } fsm_e;

  // one byte through the CRC, bit by bit, most significant first
  function automatic logic [7:0] crc8_step(input logic [7:0] crc_in, input logic [7:0] data);
    logic [7:0] c;
    logic fb;
    c = crc_in;
    for (int i = 7; i >= 0; i--) begin
      fb = c[7] ^ data[i];
      c  = {c[6:0], 1'b0} ^ (fb ? CRC_POLY : 8'h00);
    end
    return c;
  endfunction

  // payload size from the two length bits
  function automatic logic [3:0] len_bytes(input logic [1:0] code);
    return 4'd1 << code;
  endfunction

endpackage

// File: rtl/spi_byte_shifter.sv
module spi_byte_shifter #(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sclk,
  input  logic       csel_n,
  input  logic       mosi,
  input  logic       abort,
  input  logic       tx_load,
  input  logic [7:0] tx_byte,
  output logic       miso,
  output logic       byte_done,
  output logic [7:0] rx_byte,
  output logic       bit_idle
);
  import spi_cmd_pkg::*;

  localparam int TOP = SYNC_STAGES - 1;

  logic [TOP:0] sclk_q, mosi_q, cs_q;
  logic         sclk_d;
  logic [2:0]   bit_cnt;
  logic [7:0]   rx_sr, tx_sr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_q <= '0;
      mosi_q <= '0;
      cs_q   <= '1;
      sclk_d <= 1'b0;
    end else begin
      sclk_q <= {sclk_q[TOP-1:0], sclk};
      mosi_q <= {mosi_q[TOP-1:0], mosi};
      cs_q   <= {cs_q[TOP-1:0], csel_n};
      sclk_d <= sclk_q[TOP];
    end
  end

  logic sel, sck_rise, sck_fall;
  assign sel      = ~cs_q[TOP];
  assign sck_rise = sel &  sclk_q[TOP] & ~sclk_d;
  assign sck_fall = sel & ~sclk_q[TOP] &  sclk_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bit_cnt   <= '0;
      rx_sr     <= '0;
      rx_byte   <= '0;
      byte_done <= 1'b0;
    end else begin
      byte_done <= 1'b0;
      if (abort || !sel) begin
        bit_cnt <= '0;
      end else if (sck_rise) begin
        rx_sr <= {rx_sr[6:0], mosi_q[TOP]};
        if (bit_cnt == 3'd7) begin
          rx_byte   <= {rx_sr[6:0], mosi_q[TOP]};
          byte_done <= 1'b1;
        end
        bit_cnt <= bit_cnt + 3'd1;
      end
    end
  end

  // no shift on the falling edge that trails the eighth bit
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      tx_sr <= HDR_CMD;
    else if (tx_load)
      tx_sr <= tx_byte;
    else if (sck_fall && bit_cnt != 3'd0)
      tx_sr <= {tx_sr[6:0], 1'b0};
  end

  assign miso     = tx_sr[7];
  assign bit_idle = (bit_cnt == 3'd0);

  // R2: every assembled byte is reported exactly once
  p_done_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
    byte_done |=> !byte_done);

endmodule

// File: rtl/spi_idle_timer.sv
module spi_idle_timer #(
  parameter int TMO_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             restart,
  input  logic [TMO_W-1:0] limit,
  output logic             expired
);
  logic [TMO_W-1:0] cnt;

  assign expired = run && !restart && (limit != '0) && (cnt == limit - 1'b1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      cnt <= '0;
    else if (!run || restart || expired)
      cnt <= '0;
    else
      cnt <= cnt + 1'b1;
  end

  // R8: a restart always grants at least one quiet cycle before expiry
  p_restart_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (restart && limit > 1 && $stable(limit)) |=> !expired);

endmodule

// File: rtl/spi_frame_ctrl.sv
module spi_frame_ctrl #(
  parameter int DATA_BYTES = 8
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           byte_done,
  input  logic [7:0]                     rx_byte,
  input  logic                           bit_idle,
  input  logic                           crc_en,
  input  logic                           reg_busy,
  input  logic [8*DATA_BYTES-1:0]        reg_rdata,
  input  logic                           tmo_expired,
  output logic                           tx_load,
  output logic [7:0]                     tx_byte,
  output logic                           frame_run,
  output logic                           byte_abort,
  output logic                           reg_rd,
  output logic                           reg_wr,
  output logic [spi_cmd_pkg::ADDR_W-1:0] reg_addr,
  output logic [8*DATA_BYTES-1:0]        reg_wdata
);
  import spi_cmd_pkg::*;

  localparam int DATA_W = 8 * DATA_BYTES;
  localparam int IDX_W  = (DATA_BYTES > 1) ? $clog2(DATA_BYTES) : 1;

  fsm_e              state, nstate;
  logic              is_wr;
  logic [3:0]        len_q, idx_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wbuf, rbuf;
  logic [7:0]        crc_q;

  // internal events, named for the assertions
  logic       go_decide, accept, crc_good, last_idx;
  logic [7:0] crc_next, rbyte_next;

  assign crc_next   = crc8_step(crc_q, rx_byte);
  assign last_idx   = (idx_q == len_q - 4'd1);
  assign crc_good   = (state != ST_CRC) || (rx_byte == crc_q);
  assign accept     = crc_good && !reg_busy;
  assign rbyte_next = (state == ST_STAT) ? rbuf[7:0]
                                         : rbuf[8*(idx_q[IDX_W-1:0] + 1'b1) +: 8];

  always_comb begin
    nstate    = state;
    tx_load   = 1'b0;
    tx_byte   = FILL;
    go_decide = 1'b0;
    if (tmo_expired) begin
      nstate  = ST_CMD;
      tx_load = 1'b1;
      tx_byte = HDR_CMD;
    end else if (byte_done) begin
      tx_load = 1'b1;
      unique case (state)
        ST_CMD:  begin nstate = ST_ADR; tx_byte = HDR_ADR; end
        ST_ADR:  if (is_wr) nstate = ST_WDAT;
                 else if (crc_en) nstate = ST_CRC;
                 else go_decide = 1'b1;
        ST_WDAT: if (last_idx) begin
                   if (crc_en) nstate = ST_CRC;
                   else go_decide = 1'b1;
                 end
        ST_CRC:  go_decide = 1'b1;
        ST_STAT: if (is_wr) begin nstate = ST_CMD; tx_byte = HDR_CMD; end
                 else begin nstate = ST_RDAT; tx_byte = rbyte_next; end
        ST_RDAT: if (last_idx) begin nstate = ST_CMD; tx_byte = HDR_CMD; end
                 else tx_byte = rbyte_next;
        ST_NSTAT: if (reg_busy) begin nstate = ST_HOLD; tx_byte = RSP_NACK; end
                  else begin nstate = ST_CMD; tx_byte = HDR_CMD; end
        default: tx_byte = RSP_NACK; // ST_HOLD: discard
      endcase
      if (go_decide) begin
        nstate  = accept ? ST_STAT : ST_NSTAT;
        tx_byte = accept ? RSP_ACK : RSP_NACK;
      end
    end else if (state == ST_HOLD && !reg_busy && bit_idle) begin
      nstate  = ST_CMD;
      tx_load = 1'b1;
      tx_byte = HDR_CMD;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= ST_CMD;
      is_wr  <= 1'b0;
      len_q  <= 4'd1;
      idx_q  <= '0;
      addr_q <= '0;
      wbuf   <= '0;
      rbuf   <= '0;
      crc_q  <= '0;
      reg_rd <= 1'b0;
      reg_wr <= 1'b0;
    end else begin
      state  <= nstate;
      reg_rd <= go_decide && accept && !is_wr;
      reg_wr <= go_decide && accept &&  is_wr;
      if (reg_rd) rbuf <= reg_rdata;
      if (byte_done) begin
        unique case (state)
          ST_CMD: begin
            is_wr        <= rx_byte[7];
            len_q        <= len_bytes(rx_byte[5:4]);
            addr_q[11:8] <= rx_byte[3:0];
            wbuf         <= '0;
            crc_q        <= crc8_step(8'h00, rx_byte);
            idx_q        <= '0;
          end
          ST_ADR: begin
            addr_q[7:0] <= rx_byte;
            crc_q       <= crc_next;
            idx_q       <= '0;
          end
          ST_WDAT: begin
            wbuf[8*idx_q[IDX_W-1:0] +: 8] <= rx_byte;
            crc_q <= crc_next;
            idx_q <= idx_q + 4'd1;
          end
          ST_STAT: idx_q <= '0;
          ST_RDAT: idx_q <= idx_q + 4'd1;
          default: ;
        endcase
      end
    end
  end

  assign reg_addr   = addr_q;
  assign reg_wdata  = wbuf;
  assign byte_abort = tmo_expired;
  assign frame_run  = (state != ST_HOLD) && (state != ST_CMD || !bit_idle);

  // R5: a write strobe is a single pulse
  p_wr_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wr |=> !reg_wr);

  // R4: a read strobe is a single pulse
  p_rd_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
    reg_rd |=> !reg_rd);

  // R7: no strobe follows a cycle in which busy was high
  p_no_strobe_busy_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr || reg_rd) |-> !$past(reg_busy));

  // R7: the discard state never touches the register bus
  p_hold_silent_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_HOLD) |-> !(reg_wr || reg_rd));

  // R6: a wrong check byte always leads to the rejecting status
  p_crc_bad_nack_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_CRC && byte_done && rx_byte != crc_q) |=> (state == ST_NSTAT && !reg_wr && !reg_rd));

  // R8: an expiry leaves the engine waiting for a command, framer cleared
  p_timeout_to_cmd_r8: assert property (@(posedge clk) disable iff (!rst_n)
    tmo_expired |=> (state == ST_CMD && bit_idle));

endmodule

// File: rtl/spi_cmd_engine.sv
module spi_cmd_engine #(
  parameter int DATA_BYTES  = 8,
  parameter int TMO_W       = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           spi_sclk,
  input  logic                           spi_csn,
  input  logic                           spi_mosi,
  output logic                           spi_miso,
  input  logic                           cfg_crc_en,
  input  logic [TMO_W-1:0]               cfg_timeout,
  input  logic                           reg_busy,
  output logic                           reg_rd,
  output logic                           reg_wr,
  output logic [spi_cmd_pkg::ADDR_W-1:0] reg_addr,
  output logic [8*DATA_BYTES-1:0]        reg_wdata,
  input  logic [8*DATA_BYTES-1:0]        reg_rdata
);

  logic       byte_done, bit_idle, tx_load, frame_run, byte_abort, tmo_expired;
  logic [7:0] rx_byte, tx_byte;

  spi_byte_shifter #(.SYNC_STAGES(SYNC_STAGES)) u_shift (
    .clk       (clk),
    .rst_n     (rst_n),
    .sclk      (spi_sclk),
    .csel_n    (spi_csn),
    .mosi      (spi_mosi),
    .abort     (byte_abort),
    .tx_load   (tx_load),
    .tx_byte   (tx_byte),
    .miso      (spi_miso),
    .byte_done (byte_done),
    .rx_byte   (rx_byte),
    .bit_idle  (bit_idle)
  );

  spi_idle_timer #(.TMO_W(TMO_W)) u_timer (
    .clk     (clk),
    .rst_n   (rst_n),
    .run     (frame_run),
    .restart (byte_done),
    .limit   (cfg_timeout),
    .expired (tmo_expired)
  );

  spi_frame_ctrl #(.DATA_BYTES(DATA_BYTES)) u_ctrl (
    .clk         (clk),
    .rst_n       (rst_n),
    .byte_done   (byte_done),
    .rx_byte     (rx_byte),
    .bit_idle    (bit_idle),
    .crc_en      (cfg_crc_en),
    .reg_busy    (reg_busy),
    .reg_rdata   (reg_rdata),
    .tmo_expired (tmo_expired),
    .tx_load     (tx_load),
    .tx_byte     (tx_byte),
    .frame_run   (frame_run),
    .byte_abort  (byte_abort),
    .reg_rd      (reg_rd),
    .reg_wr      (reg_wr),
    .reg_addr    (reg_addr),
    .reg_wdata   (reg_wdata)
  );

endmodule

// File: tb/test_spi_cmd_engine.sv
module test_spi_cmd_engine;

  localparam int HALF = 8;
  localparam int GAP  = 16;
  localparam logic [63:0] RD_BASE = 64'h0F1E_2D3C_4B5A_6978;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        spi_sclk, spi_csn, spi_mosi, spi_miso;
  logic        cfg_crc_en;
  logic [15:0] cfg_timeout;
  logic        reg_busy, reg_rd, reg_wr;
  logic [11:0] reg_addr;
  logic [63:0] reg_wdata, reg_rdata;

  always #4 clk = ~clk;

  // register side model: read data depends on the address
  assign reg_rdata = RD_BASE ^ {52'd0, reg_addr};

  spi_cmd_engine i_spi_cmd_engine (
    .clk(clk), .rst_n(rst_n), .spi_sclk(spi_sclk), .spi_csn(spi_csn),
    .spi_mosi(spi_mosi), .spi_miso(spi_miso), .cfg_crc_en(cfg_crc_en),
    .cfg_timeout(cfg_timeout), .reg_busy(reg_busy), .reg_rd(reg_rd),
    .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata)
  );

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // bus monitor, every clock
  int          wr_seen = 0, rd_seen = 0;
  logic [11:0] last_addr;
  logic [63:0] last_wdata;
  always @(negedge clk) begin
    if (rst_n && (reg_wr || reg_rd)) begin
      if (reg_wr) begin wr_seen++; last_wdata = reg_wdata; end
      if (reg_rd) rd_seen++;
      last_addr = reg_addr;
      chk(!reg_busy, "R7 strobe while busy", 64'(reg_busy), 64'd0);
    end
  end

  function automatic logic [7:0] ref_crc(input logic [7:0] c, input logic [7:0] b);
    logic [7:0] r;
    r = c ^ b;
    for (int k = 0; k < 8; k++)
      r = r[7] ? ((r << 1) ^ 8'h07) : (r << 1);
    return r;
  endfunction

  task automatic xfer(input logic [7:0] mo, output logic [7:0] mi);
    for (int i = 7; i >= 0; i--) begin
      spi_mosi = mo[i];
      repeat (HALF) @(negedge clk);
      mi[i] = spi_miso;
      spi_sclk = 1'b1;
      repeat (HALF) @(negedge clk);
      spi_sclk = 1'b0;
    end
    repeat (GAP) @(negedge clk);
  endtask

  // crc_mode: 0 none, 1 correct, 2 corrupted
  task automatic frame(input bit wr, input logic [1:0] lc, input logic [11:0] a,
                       input logic [63:0] wd, input int crc_mode, input int pause,
                       input string tag);
    int          n;
    logic [7:0]  cmd, r, c, b;
    logic [63:0] rd, wexp;
    bit          acc;
    int          w0, r0;
    n   = 1 << lc;
    cmd = {wr, 1'b0, lc, a[11:8]};
    cfg_crc_en = (crc_mode != 0);
    acc = !reg_busy && (crc_mode != 2);
    w0 = wr_seen; r0 = rd_seen;
    c = 8'h00;
    xfer(cmd, r);  chk(r == 8'hC1, {tag, " R1 cmd header"}, 64'(r), 64'hC1);
    c = ref_crc(c, cmd);
    repeat (pause) @(negedge clk);
    xfer(a[7:0], r); chk(r == 8'hC2, {tag, " R1 addr header"}, 64'(r), 64'hC2);
    c = ref_crc(c, a[7:0]);
    wexp = 64'd0;
    if (wr) begin
      for (int k = 0; k < n; k++) begin
        b = wd[8*k +: 8];
        wexp[8*k +: 8] = b;
        xfer(b, r); chk(r == 8'h00, {tag, " R5 fill during data"}, 64'(r), 64'h0);
        c = ref_crc(c, b);
      end
    end
    if (crc_mode != 0) begin
      b = (crc_mode == 2) ? (c ^ 8'h5A) : c;
      xfer(b, r); chk(r == 8'h00, {tag, " R6 fill during crc"}, 64'(r), 64'h0);
    end
    xfer(8'h00, r);
    chk(r == (acc ? 8'h41 : 8'h4E), {tag, " R3 status"}, 64'(r), acc ? 64'h41 : 64'h4E);
    if (acc && !wr) begin
      rd = RD_BASE ^ {52'd0, a};
      for (int k = 0; k < n; k++) begin
        xfer(8'hFF, r);
        chk(r == rd[8*k +: 8], {tag, " R4 read byte"}, 64'(r), 64'(rd[8*k +: 8]));
      end
    end
    chk((wr_seen - w0) == ((acc && wr) ? 1 : 0), {tag, " R5 R6 R7 write strobes"},
        64'(wr_seen - w0), (acc && wr) ? 64'd1 : 64'd0);
    chk((rd_seen - r0) == ((acc && !wr) ? 1 : 0), {tag, " R4 R6 R7 read strobes"},
        64'(rd_seen - r0), (acc && !wr) ? 64'd1 : 64'd0);
    if (acc) begin
      chk(last_addr == a, {tag, " R2 address"}, 64'(last_addr), 64'(a));
      if (wr) chk(last_wdata == wexp, {tag, " R5 write data"}, last_wdata, wexp);
    end
  endtask

  initial begin
    logic [7:0] r;
    int w0, r0;
    rst_n = 1'b0; spi_sclk = 1'b0; spi_csn = 1'b0; spi_mosi = 1'b0;
    cfg_crc_en = 1'b0; cfg_timeout = 16'd1000; reg_busy = 1'b0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    chk(spi_miso == 1'b1, "R1 miso after reset", 64'(spi_miso), 64'd1);
    chk(!reg_wr && !reg_rd, "R1 no strobe after reset", 64'({reg_wr, reg_rd}), 64'd0);

    frame(1'b0, 2'd0, 12'h123, 64'd0, 0, 0, "R2 read1");
    frame(1'b0, 2'd3, 12'hA5C, 64'd0, 0, 0, "R4 read8");
    frame(1'b1, 2'd1, 12'h3F0, 64'hFFFF_0000_CAFE_BEEF, 0, 0, "R5 write2");
    frame(1'b1, 2'd2, 12'h7E1, 64'h1122_3344_5566_7788, 1, 0, "R6 write4 crc good");
    frame(1'b1, 2'd0, 12'h045, 64'h0000_0000_0000_0099, 2, 0, "R6 write1 crc bad");
    frame(1'b0, 2'd1, 12'hB02, 64'd0, 1, 0, "R6 read2 crc good");
    frame(1'b0, 2'd2, 12'h0D7, 64'd0, 2, 0, "R6 read4 crc bad");
    frame(1'b1, 2'd3, 12'hFFF, 64'h0102_0304_0506_0708, 0, 0, "R9 write8 back to back");

    // busy: reject, then discard while held
    reg_busy = 1'b1;
    frame(1'b0, 2'd0, 12'h010, 64'd0, 0, 0, "R7 busy read");
    w0 = wr_seen; r0 = rd_seen;
    xfer(8'h80, r); chk(r == 8'h4E, "R7 discarded byte", 64'(r), 64'h4E);
    xfer(8'h12, r); chk(r == 8'h4E, "R7 discarded byte 2", 64'(r), 64'h4E);
    chk((wr_seen == w0) && (rd_seen == r0), "R7 no strobe in hold", 64'(wr_seen - w0 + rd_seen - r0), 64'd0);
    reg_busy = 1'b0;
    repeat (10) @(negedge clk);
    frame(1'b0, 2'd0, 12'h011, 64'd0, 0, 0, "R9 after hold");

    // timeout drops a stalled write
    cfg_timeout = 16'd200;
    cfg_crc_en  = 1'b0;
    w0 = wr_seen;
    xfer(8'h90, r); chk(r == 8'hC1, "R8 stalled cmd header", 64'(r), 64'hC1);
    xfer(8'h33, r); chk(r == 8'hC2, "R8 stalled addr header", 64'(r), 64'hC2);
    repeat (400) @(negedge clk);
    frame(1'b0, 2'd0, 12'h222, 64'd0, 0, 0, "R8 after timeout");
    chk(wr_seen == w0, "R8 no write from dropped frame", 64'(wr_seen - w0), 64'd0);

    // timeout disabled: a long pause does not break the frame
    cfg_timeout = 16'd0;
    frame(1'b0, 2'd1, 12'h333, 64'd0, 0, 3000, "R8 timer disabled");
    cfg_timeout = 16'd1000;

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: run did not complete, actual=hung expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule